// File: doc/BRIEF.md
# Pipeline Operand Forwarding Unit

This block supplies the two ALU operands of the execute stage in a five-stage, in-order integer pipeline. A result may not yet have reached the register file, and the block decides for each operand whether the value read from the register file is stale. It compares both source register numbers of the instruction in execute against the destination numbers of the two older instructions. Those older instructions sit in the execute/memory and memory/writeback pipeline registers. When a match is live, the newer value is steered straight to the ALU input.

The selection logic is purely combinational. A thin wrapper adds the two three-way operand multiplexers so the unit can be exercised alone. A producer three instructions ahead has already written the register file in the first half of the cycle, so it needs no forwarding.

Top module: `fwd_datapath`

## Requirements
- R1: With no live match on a source, its select is 2'b00 and the ALU operand equals the register-file value for that source.
- R2: When the execute/memory stage writes (write enable 1) a nonzero register equal to the A source, `sel_a` is 2'b10 and `alu_a` equals `exm_result`.
- R3: When only the memory/writeback stage writes a nonzero register equal to the A source, `sel_a` is 2'b01 and `alu_a` equals `wb_value`.
- R4: Operand B follows the same rules against the B source, with 2'b10 for the execute/memory value and 2'b01 for the writeback value.
- R5: A stage whose write enable is 0 never causes forwarding, whatever its destination number.
- R6: Destination register 0 never causes forwarding, even with its write enable at 1.
- R7: When both stages match the same source, the execute/memory (younger) value wins and the select is 2'b10.
- R8: The two operands are decided independently. In one cycle, A may forward from one stage while B forwards from the other.
- R9: A producer three or more instructions ahead of the consumer causes no forwarding. In a sequence where a subtract writes r2 and is followed by and, or, add and store that read r2, the and forwards from execute/memory, the or forwards from writeback, and the add and store read the register file.
- R10: A select never takes the value 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_rs | input | 5 | A source register number of the instruction in execute |
| ex_rt | input | 5 | B source register number of the instruction in execute |
| exm_rd | input | 5 | Destination register of the execute/memory stage |
| exm_wen | input | 1 | Register write enable of the execute/memory stage |
| wb_rd | input | 5 | Destination register of the memory/writeback stage |
| wb_wen | input | 1 | Register write enable of the memory/writeback stage |
| rf_a | input | 32 | Register-file read value for the A source |
| rf_b | input | 32 | Register-file read value for the B source |
| exm_result | input | 32 | ALU result held in execute/memory |
| wb_value | input | 32 | Write-back value held in memory/writeback |
| alu_a | output | 32 | Selected A operand |
| alu_b | output | 32 | Selected B operand |
| sel_a | output | 2 | A operand select (00 file, 10 execute/memory, 01 writeback) |
| sel_b | output | 2 | B operand select (same encoding) |

## Verification
The assertions assume the stage fields are a coherent snapshot of a real pipeline. The destination and write enable of each stage belong to one instruction, and all inputs change together between clock edges. The bench meets this by shifting whole instruction records through a modelled pipeline on each clock and driving every port from that model at once. It feeds a directed program (the r2 dependency chain, register-0 writes, disabled writes, double matches and split forwarding), then a long stream over a few registers so that matches are frequent.

// File: rtl/fwd_pkg.sv
// Package: shared widths and the operand select encoding.
// Assumes a 32-entry register file with register 0 hardwired to zero.
package fwd_pkg;
    parameter int REG_W  = 5;
    parameter int DATA_W = 32;

    // Operand source select; the encoding is visible at the ports.
    typedef enum logic [1:0] {
        SEL_FILE = 2'b00,
        SEL_WB   = 2'b01,
        SEL_EXM  = 2'b10
    } opsel_t;
endpackage

// File: rtl/fwd_match.sv
// Module: fwd_match
// Flags a live dependency between one source number and one older stage.
// Assumes stage_rd and stage_wen come from the same pipeline register.
module fwd_match #(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] src,
    input  logic [REG_W-1:0] stage_rd,
    input  logic             stage_wen,
    output logic             hit
);
    localparam logic [REG_W-1:0] ZERO_REG = '0;

    // Purpose: a stage counts only when it writes a real register equal to src.
    always_comb begin
        hit = stage_wen && (stage_rd != ZERO_REG) && (stage_rd == src);
    end

    // Purpose: guard register-zero and write-enable exclusions.
    always_comb begin
        if (stage_rd == ZERO_REG) p_zero_never_hits_r6: assert (!hit);
        if (!stage_wen)           p_disabled_never_hits_r5: assert (!hit);
    end
endmodule

// File: rtl/fwd_select.sv
// Module: fwd_select
// Turns the two stage hits of one operand into a select, younger stage first.
// Assumes at most the two listed stages can hold an unwritten result.
module fwd_select
    import fwd_pkg::*;
(
    input  logic   hit_exm,
    input  logic   hit_wb,
    output opsel_t sel
);
    // Purpose: age priority, the execute/memory value is newer than writeback.
    always_comb begin
        if (hit_exm)     sel = SEL_EXM;
        else if (hit_wb) sel = SEL_WB;
        else             sel = SEL_FILE;
    end

    // Purpose: the unused code 2'b11 must never appear.
    always_comb begin
        p_no_illegal_code_r10: assert (sel != opsel_t'(2'b11));
    end
endmodule

// File: rtl/fwd_unit.sv
// Module: fwd_unit
// Forwarding decision for both ALU operands; one match/select slice each.
// Assumes sources index 0 = A (rs), index 1 = B (rt).
module fwd_unit
    import fwd_pkg::*;
#(
    parameter int REG_W   = fwd_pkg::REG_W,
    parameter int N_OPND  = 2
) (
    input  logic [REG_W-1:0] src   [N_OPND],
    input  logic [REG_W-1:0] exm_rd,
    input  logic             exm_wen,
    input  logic [REG_W-1:0] wb_rd,
    input  logic             wb_wen,
    output opsel_t           sel   [N_OPND]
);
    localparam logic [REG_W-1:0] ZERO_REG = '0;

    for (genvar i = 0; i < N_OPND; i++) begin : g_opnd
        logic hit_exm;
        logic hit_wb;

        fwd_match #(.REG_W(REG_W)) u_m_exm (
            .src(src[i]), .stage_rd(exm_rd), .stage_wen(exm_wen), .hit(hit_exm)
        );
        fwd_match #(.REG_W(REG_W)) u_m_wb (
            .src(src[i]), .stage_rd(wb_rd), .stage_wen(wb_wen), .hit(hit_wb)
        );
        fwd_select u_sel (.hit_exm(hit_exm), .hit_wb(hit_wb), .sel(sel[i]));

        // Purpose: port-level relation between stage fields and the select.
        always_comb begin
            if (exm_wen && exm_rd != ZERO_REG && exm_rd == src[i])
                p_young_wins_r7: assert (sel[i] == SEL_EXM);
            if (!(exm_wen && exm_rd == src[i]) && !(wb_wen && wb_rd == src[i]))
                p_no_match_file_r1: assert (sel[i] == SEL_FILE);
            if (sel[i] == SEL_WB)
                p_wb_needs_match_r3: assert (wb_wen && wb_rd == src[i] && src[i] != ZERO_REG);
        end
    end
endmodule

// File: rtl/opnd_mux.sv
// Module: opnd_mux
// Three-way operand multiplexer driven by an opsel_t select.
// Assumes the select is one of the three legal codes.
module opnd_mux
    import fwd_pkg::*;
#(
    parameter int DATA_W = fwd_pkg::DATA_W
) (
    input  opsel_t            sel,
    input  logic [DATA_W-1:0] from_file,
    input  logic [DATA_W-1:0] from_exm,
    input  logic [DATA_W-1:0] from_wb,
    output logic [DATA_W-1:0] y
);
    // Purpose: steer the chosen source to the ALU input.
    always_comb begin
        unique case (sel)
            SEL_EXM: y = from_exm;
            SEL_WB:  y = from_wb;
            default: y = from_file;
        endcase
    end
endmodule

// File: rtl/fwd_datapath.sv
// Module: fwd_datapath (top)
// Forwarding unit plus both ALU operand multiplexers, combinational end to end.
// Assumes all inputs are a consistent snapshot of the pipeline registers.
module fwd_datapath
    import fwd_pkg::*;
#(
    parameter int REG_W  = fwd_pkg::REG_W,
    parameter int DATA_W = fwd_pkg::DATA_W
) (
    input  logic [REG_W-1:0]  ex_rs,
    input  logic [REG_W-1:0]  ex_rt,
    input  logic [REG_W-1:0]  exm_rd,
    input  logic              exm_wen,
    input  logic [REG_W-1:0]  wb_rd,
    input  logic              wb_wen,
    input  logic [DATA_W-1:0] rf_a,
    input  logic [DATA_W-1:0] rf_b,
    input  logic [DATA_W-1:0] exm_result,
    input  logic [DATA_W-1:0] wb_value,
    output logic [DATA_W-1:0] alu_a,
    output logic [DATA_W-1:0] alu_b,
    output logic [1:0]        sel_a,
    output logic [1:0]        sel_b
);
    localparam int N_OPND = 2;

    logic [REG_W-1:0]  src  [N_OPND];
    logic [DATA_W-1:0] file [N_OPND];
    logic [DATA_W-1:0] outv [N_OPND];
    opsel_t            sel  [N_OPND];

    // Purpose: gather per-operand inputs into arrays for the generate loop.
    always_comb begin
        src[0]  = ex_rs;
        src[1]  = ex_rt;
        file[0] = rf_a;
        file[1] = rf_b;
    end

    fwd_unit #(.REG_W(REG_W), .N_OPND(N_OPND)) u_unit (
        .src(src), .exm_rd(exm_rd), .exm_wen(exm_wen),
        .wb_rd(wb_rd), .wb_wen(wb_wen), .sel(sel)
    );

    for (genvar i = 0; i < N_OPND; i++) begin : g_mux
        opnd_mux #(.DATA_W(DATA_W)) u_mux (
            .sel(sel[i]), .from_file(file[i]), .from_exm(exm_result),
            .from_wb(wb_value), .y(outv[i])
        );
    end

    // Purpose: drive the ports from the operand slices.
    always_comb begin
        alu_a = outv[0];
        alu_b = outv[1];
        sel_a = sel[0];
        sel_b = sel[1];
    end

    // Purpose: selects and multiplexed data must agree at the ports.
    always_comb begin
        if (sel_a == 2'b10) p_a_takes_exm_r2: assert (alu_a == exm_result);
        if (sel_b == 2'b10) p_b_takes_exm_r4: assert (alu_b == exm_result);
        if (sel_b == 2'b01) p_b_takes_wb_r4:  assert (alu_b == wb_value);
        if (sel_a == 2'b00) p_a_takes_file_r1: assert (alu_a == rf_a);
    end
endmodule

// File: tb/sim_fwd_datapath.sv
// Bench: a pipeline of instruction records is shifted every clock; the
// expected selects come from an age-ordered search over the older stages.
module sim_fwd_datapath;
    typedef struct packed {
        logic [4:0] rd;
        logic [4:0] rs;
        logic [4:0] rt;
        logic       wen;
    } ins_t;

    localparam ins_t NOP = '{rd: 5'd0, rs: 5'd0, rt: 5'd0, wen: 1'b0};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic [4:0]  ex_rs, ex_rt, exm_rd, wb_rd;
    logic        exm_wen, wb_wen;
    logic [31:0] rf_a, rf_b, exm_result, wb_value, alu_a, alu_b;
    logic [1:0]  sel_a, sel_b;

    fwd_datapath u0 (
        .ex_rs(ex_rs), .ex_rt(ex_rt), .exm_rd(exm_rd), .exm_wen(exm_wen),
        .wb_rd(wb_rd), .wb_wen(wb_wen), .rf_a(rf_a), .rf_b(rf_b),
        .exm_result(exm_result), .wb_value(wb_value),
        .alu_a(alu_a), .alu_b(alu_b), .sel_a(sel_a), .sel_b(sel_b)
    );

    int n_cmp = 0;
    int n_bad = 0;
    ins_t prog[$];
    ins_t st_ex = NOP, st_exm = NOP, st_wb = NOP;
    bit done = 0;

    function automatic ins_t mk(int rd, int rs, int rt, bit wen);
        ins_t t;
        t.rd = rd[4:0]; t.rs = rs[4:0]; t.rt = rt[4:0]; t.wen = wen;
        return t;
    endfunction

    // Reference: scan older stages youngest first, return 2=exm, 1=wb, 0=file.
    function automatic int ref_src(logic [4:0] s, ins_t exm, ins_t wb);
        ins_t older[$];
        older.push_back(exm);
        older.push_back(wb);
        foreach (older[k])
            if (older[k].wen && older[k].rd != 0 && older[k].rd == s)
                return 2 - k;
        return 0;
    endfunction

    task automatic check(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_opnd(bit is_b, logic [4:0] s, logic [1:0] sel_act,
                              logic [31:0] val_act, logic [31:0] file_v);
        int    exp;
        string tag;
        logic [31:0] vexp;
        exp = ref_src(s, st_exm, st_wb);
        if (exp == 2 && st_wb.wen && st_wb.rd == s)        tag = "R7";
        else if (exp != 0)                                  tag = is_b ? "R4" : (exp == 2 ? "R2" : "R3");
        else if (s == 0 && (st_exm.rd == 0 || st_wb.rd == 0)) tag = "R6";
        else if ((st_exm.rd == s && !st_exm.wen) || (st_wb.rd == s && !st_wb.wen)) tag = "R5";
        else                                                tag = "R1";
        vexp = (exp == 2) ? exm_result : (exp == 1) ? wb_value : file_v;
        check({tag, " sel"}, sel_act, (exp == 2) ? 2 : (exp == 1) ? 1 : 0);
        check({tag, " data"}, val_act, vexp);
        check("R10 legal code", (sel_act == 2'b11), 0);
    endtask

    task automatic drive();
        ex_rs = st_ex.rs;   ex_rt = st_ex.rt;
        exm_rd = st_exm.rd; exm_wen = st_exm.wen;
        wb_rd = st_wb.rd;   wb_wen = st_wb.wen;
        rf_a = $urandom; rf_b = $urandom;
        exm_result = $urandom; wb_value = $urandom;
    endtask

    initial begin
        // R9 chain: sub r2,r1,r3 ; and r12,r2,r5 ; or r13,r6,r2 ; add r14,r2,r2 ; sw r15,100(r2)
        prog.push_back(mk(2, 1, 3, 1));
        prog.push_back(mk(12, 2, 5, 1));
        prog.push_back(mk(13, 6, 2, 1));
        prog.push_back(mk(14, 2, 2, 1));
        prog.push_back(mk(0, 2, 15, 0));
        // R6: writes to r0 do not forward
        prog.push_back(mk(0, 4, 5, 1));
        prog.push_back(mk(0, 6, 7, 1));
        prog.push_back(mk(9, 0, 0, 1));
        // R5: disabled write to r7
        prog.push_back(mk(7, 1, 1, 0));
        prog.push_back(mk(8, 7, 7, 1));
        // R7: two writes to r9, then a read
        prog.push_back(mk(9, 1, 1, 1));
        prog.push_back(mk(9, 2, 2, 1));
        prog.push_back(mk(10, 9, 9, 1));
        // R8: write r4, write r5, read A=r5 B=r4
        prog.push_back(mk(4, 1, 1, 1));
        prog.push_back(mk(5, 1, 1, 1));
        prog.push_back(mk(11, 5, 4, 1));
        // R4: B operand from execute/memory
        prog.push_back(mk(8, 1, 1, 1));
        prog.push_back(mk(3, 1, 8, 1));
        for (int i = 0; i < 400; i++)
            prog.push_back(mk($urandom_range(0, 3), $urandom_range(0, 3),
                              $urandom_range(0, 3), 1'($urandom_range(0, 1))));

        drive();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // Reset state: empty pipeline, file values pass through (R1)
        check("R1 reset sel_a", sel_a, 0);
        check("R1 reset sel_b", sel_b, 0);
        check("R1 reset alu_a", alu_a, rf_a);
        rst_n = 1'b1;

        for (int cyc = 0; prog.size() > 0 || cyc < 3; cyc++) begin
            @(posedge clk);
            #1;
            st_wb  = st_exm;
            st_exm = st_ex;
            st_ex  = (prog.size() > 0) ? prog.pop_front() : NOP;
            drive();
            @(negedge clk);
            check_opnd(1'b0, st_ex.rs, sel_a, alu_a, rf_a);
            check_opnd(1'b1, st_ex.rt, sel_b, alu_b, rf_b);
            // R8: A and B decided independently on split sources
            if (ref_src(st_ex.rs, st_exm, st_wb) == 1 && ref_src(st_ex.rt, st_exm, st_wb) == 2)
                check("R8 split B", sel_b, 2);
            if (ref_src(st_ex.rs, st_exm, st_wb) == 2 && ref_src(st_ex.rt, st_exm, st_wb) == 1)
                check("R8 split B", sel_b, 1);
            // R9 fixed points of the r2 chain (cycle index = consumer position)
            if (cyc == 1) check("R9 and from exm", sel_a, 2);
            if (cyc == 2) check("R9 or from wb", sel_b, 1);
            if (cyc == 3) check("R9 add from file", {sel_a, sel_b}, 0);
            if (cyc == 4) check("R9 store from file", sel_a, 0);
        end
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_cmp++;
                n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule